// File: doc/BRIEF.md
# Internal Data Memory Unit for an 8051-Class Core

This block holds the on-chip data storage of an 8051-compatible processor and routes every data access to the right place. The core presents one request per cycle with an operation code, an address, an optional write byte and a write flag. The unit resolves the request to one of four stores: the lower 128-byte RAM, the upper 128-byte RAM, a small set of special function registers, or a 768-byte expanded RAM reached through MOVX. MOVX requests that fall outside the expanded RAM raise a one-cycle external request strobe instead.

The unit owns the stack pointer, the 16-bit data pointer, the program status byte whose bits 4:3 select the working register bank, and the system-control byte whose bit 0 enables the expanded RAM. It turns register references R0 to R7 into physical lower-RAM addresses and performs single-bit writes as read-modify-write cycles. Operation codes on `req_op` are: 0 direct, 1 indirect, 2 bit, 3 MOVX, 4 working register, 5 push, 6 pop; code 7 selects no target.

Top module: `idata_mem_unit`

## Requirements
- R1: After reset the stack pointer is 07h, the status byte (bank select) and both data pointer bytes are 00h, and the expanded RAM is disabled, so MOVX code 3 raises `ext_req`.
- R2: Bytes 00h to 7Fh are one store reached by both direct (code 0) and indirect (code 1) accesses.
- R3: Indirect accesses (code 1) to 80h to FFh reach the upper RAM; direct accesses (code 0) to 80h to FFh reach the special function registers instead.
- R4: A working-register access (code 4) to Rn, n = addr[2:0], reaches lower-RAM byte bank*8 + n, where bank is bits 4:3 of the status byte at direct address D0h.
- R5: A bit access (code 2) with bit address b below 80h reaches bit b[2:0] of byte 20h + b[6:3]; a write stores req_wdata[0] and leaves the other seven bits unchanged; a read returns 00h or 01h. Bit addresses 80h and above read 00h and change nothing.
- R6: A push (code 5) increments the stack pointer modulo 256 and then writes req_wdata at the new value, in lower RAM below 80h and in upper RAM at 80h and above.
- R7: A pop (code 6) returns the byte at the current stack pointer and then decrements it modulo 256.
- R8: The stack pointer, data pointer low byte and data pointer high byte are read and written by direct access at 81h, 82h and 83h.
- R9: Bit 0 of the system-control byte at direct address BFh enables the expanded RAM; with it set, MOVX addresses 0000h to 02FFh read and write that RAM.
- R10: A MOVX access with the enable clear or an address above 02FFh leaves every internal store untouched, pulses `ext_req` for exactly the cycle after the request with `ext_addr` holding the address, and a read returns 00h.
- R11: Read results appear on `rd_data` with `rd_valid` high in the cycle after the request, `rd_valid` stays low after writes and pushes, and an unused SFR address reads 00h and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (0 direct, 1 indirect, 2 bit, 3 MOVX, 4 register, 5 push, 6 pop) |
| req_write | input | 1 | Write when high, read when low (ignored for push and pop) |
| req_addr | input | XADDR_W | Byte, bit, register or MOVX address |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| ext_req | output | 1 | One-cycle strobe for a MOVX access not served on chip |
| ext_addr | output | XADDR_W | Address of the last external MOVX access |

## Verification
The hardest state to reach is a MOVX miss that happens while the expanded RAM already holds data at the same address: the bench fills a location with the enable set, clears the enable through the system-control byte, writes the same address, re-enables and reads back the original byte. Stack wrap needs the stack pointer loaded with FFh and with 7Fh through its direct address before pushing, so that the write lands at 00h and in the upper RAM respectively. Bank-switched register accesses are reached by rewriting the status byte between two register writes to the same Rn.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [2:0] {
        OP_DIRECT   = 3'd0,
        OP_INDIRECT = 3'd1,
        OP_BIT      = 3'd2,
        OP_XDATA    = 3'd3,
        OP_REG      = 3'd4,
        OP_PUSH     = 3'd5,
        OP_POP      = 3'd6,
        OP_NOP      = 3'd7
    } idm_op_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_LOW  = 3'd1,
        TGT_HIGH = 3'd2,
        TGT_SFR  = 3'd3,
        TGT_XRAM = 3'd4,
        TGT_EXT  = 3'd5
    } idm_tgt_e;

    localparam int          BYTE_W     = 8;
    localparam int          HALF_DEPTH = 128;
    localparam int          HALF_AW    = $clog2(HALF_DEPTH);
    localparam logic [7:0]  ADR_SP     = 8'h81;
    localparam logic [7:0]  ADR_DPL    = 8'h82;
    localparam logic [7:0]  ADR_DPH    = 8'h83;
    localparam logic [7:0]  ADR_SYSCTL = 8'hBF;
    localparam logic [7:0]  ADR_STAT   = 8'hD0;
    localparam logic [7:0]  BIT_BYTE0  = 8'h20;
    localparam logic [7:0]  SP_INIT    = 8'h07;

endpackage

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wmask,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem[addr];
            if (we) begin
                mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
            end
        end
    end
endmodule

// File: rtl/idm_route.sv
module idm_route import idm_pkg::*; #(
    parameter int XRAM_DEPTH = 768,
    parameter int XADDR_W    = 16,
    parameter int XAW        = 10
) (
    input  idm_op_e              op,
    input  logic [XADDR_W-1:0]   addr,
    input  logic [7:0]           sp,
    input  logic [1:0]           bank,
    input  logic                 xram_en,
    output idm_tgt_e             tgt,
    output logic [7:0]           idx,
    output logic [XAW-1:0]       xidx,
    output logic                 is_bit,
    output logic [2:0]           bit_pos
);
    logic [7:0] sp_up;
    logic       x_in_range;

    assign sp_up      = sp + 8'd1;
    assign x_in_range = int'(addr) < XRAM_DEPTH;

    always_comb begin
        tgt     = TGT_NONE;
        idx     = addr[7:0];
        xidx    = '0;
        is_bit  = 1'b0;
        bit_pos = '0;
        unique case (op)
            OP_DIRECT:   tgt = addr[7] ? TGT_SFR  : TGT_LOW;
            OP_INDIRECT: tgt = addr[7] ? TGT_HIGH : TGT_LOW;
            OP_REG: begin
                idx = {3'b000, bank, addr[2:0]};
                tgt = TGT_LOW;
            end
            OP_BIT: begin
                is_bit  = 1'b1;
                bit_pos = addr[2:0];
                idx     = BIT_BYTE0 + {4'b0000, addr[6:3]};
                tgt     = addr[7] ? TGT_NONE : TGT_LOW;
            end
            OP_PUSH: begin
                idx = sp_up;
                tgt = sp_up[7] ? TGT_HIGH : TGT_LOW;
            end
            OP_POP: begin
                idx = sp;
                tgt = sp[7] ? TGT_HIGH : TGT_LOW;
            end
            OP_XDATA: begin
                if (xram_en && x_in_range) begin
                    tgt  = TGT_XRAM;
                    xidx = addr[XAW-1:0];
                end else begin
                    tgt = TGT_EXT;
                end
            end
            default: tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/idata_mem_unit.sv
module idata_mem_unit import idm_pkg::*; #(
    parameter int XRAM_DEPTH = 768,
    parameter int XADDR_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic               req_write,
    input  logic [XADDR_W-1:0] req_addr,
    input  logic [7:0]         req_wdata,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               ext_req,
    output logic [XADDR_W-1:0] ext_addr
);
    localparam int XAW = $clog2(XRAM_DEPTH);

    typedef struct packed {
        logic [7:0]         sp;
        logic [7:0]         dpl;
        logic [7:0]         dph;
        logic [7:0]         stat;
        logic               xen;
        logic               rsp_valid;
        idm_tgt_e           rsp_tgt;
        logic               rsp_bit;
        logic [2:0]         rsp_pos;
        logic [7:0]         rsp_sfr;
        logic               ext_req;
        logic [XADDR_W-1:0] ext_addr;
    } state_t;

    localparam state_t STATE_RST = '{
        sp: SP_INIT, dpl: 8'h00, dph: 8'h00, stat: 8'h00, xen: 1'b0,
        rsp_valid: 1'b0, rsp_tgt: TGT_NONE, rsp_bit: 1'b0, rsp_pos: 3'd0,
        rsp_sfr: 8'h00, ext_req: 1'b0, ext_addr: '0
    };

    state_t s_d, s_q;

    idm_op_e        op;
    idm_tgt_e       tgt;
    logic [7:0]     idx;
    logic [XAW-1:0] xidx;
    logic           is_bit;
    logic [2:0]     bit_pos;
    logic           wr_eff;
    logic [7:0]     ram_mask, ram_wdata;
    logic [7:0]     low_rdata, high_rdata, x_rdata;
    logic [7:0]     sfr_rd;
    logic [7:0]     rsp_byte;
    logic [7:0]     sp_now;
    logic           xen_now;

    assign op      = idm_op_e'(req_op);
    assign sp_now  = s_q.sp;
    assign xen_now = s_q.xen;

    idm_route #(
        .XRAM_DEPTH(XRAM_DEPTH), .XADDR_W(XADDR_W), .XAW(XAW)
    ) u_route (
        .op(op), .addr(req_addr), .sp(s_q.sp), .bank(s_q.stat[4:3]),
        .xram_en(s_q.xen), .tgt(tgt), .idx(idx), .xidx(xidx),
        .is_bit(is_bit), .bit_pos(bit_pos)
    );

    assign wr_eff    = (op == OP_PUSH) || (req_write && op != OP_POP);
    assign ram_mask  = is_bit ? (8'd1 << bit_pos) : 8'hFF;
    assign ram_wdata = is_bit ? {8{req_wdata[0]}} : req_wdata;

    idm_ram #(.DEPTH(HALF_DEPTH), .AW(HALF_AW)) u_low (
        .clk(clk), .en(req_valid && tgt == TGT_LOW), .we(wr_eff),
        .addr(idx[HALF_AW-1:0]), .wmask(ram_mask), .wdata(ram_wdata),
        .rdata(low_rdata)
    );

    idm_ram #(.DEPTH(HALF_DEPTH), .AW(HALF_AW)) u_high (
        .clk(clk), .en(req_valid && tgt == TGT_HIGH), .we(wr_eff),
        .addr(idx[HALF_AW-1:0]), .wmask(ram_mask), .wdata(ram_wdata),
        .rdata(high_rdata)
    );

    idm_ram #(.DEPTH(XRAM_DEPTH), .AW(XAW)) u_xram (
        .clk(clk), .en(req_valid && tgt == TGT_XRAM), .we(wr_eff),
        .addr(xidx), .wmask(8'hFF), .wdata(req_wdata),
        .rdata(x_rdata)
    );

    always_comb begin
        unique case (idx)
            ADR_SP:     sfr_rd = s_q.sp;
            ADR_DPL:    sfr_rd = s_q.dpl;
            ADR_DPH:    sfr_rd = s_q.dph;
            ADR_STAT:   sfr_rd = s_q.stat;
            ADR_SYSCTL: sfr_rd = {7'b0000000, s_q.xen};
            default:    sfr_rd = 8'h00;
        endcase
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.ext_req   = 1'b0;
        if (req_valid) begin
            s_d.rsp_valid = !wr_eff;
            s_d.rsp_tgt   = tgt;
            s_d.rsp_bit   = is_bit;
            s_d.rsp_pos   = bit_pos;
            s_d.rsp_sfr   = sfr_rd;
            if (tgt == TGT_SFR && wr_eff) begin
                unique case (idx)
                    ADR_SP:     s_d.sp   = req_wdata;
                    ADR_DPL:    s_d.dpl  = req_wdata;
                    ADR_DPH:    s_d.dph  = req_wdata;
                    ADR_STAT:   s_d.stat = req_wdata;
                    ADR_SYSCTL: s_d.xen  = req_wdata[0];
                    default:    ;
                endcase
            end
            if (op == OP_PUSH) s_d.sp = s_q.sp + 8'd1;
            if (op == OP_POP)  s_d.sp = s_q.sp - 8'd1;
            if (tgt == TGT_EXT) begin
                s_d.ext_req  = 1'b1;
                s_d.ext_addr = req_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= STATE_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.rsp_tgt)
            TGT_LOW:  rsp_byte = low_rdata;
            TGT_HIGH: rsp_byte = high_rdata;
            TGT_XRAM: rsp_byte = x_rdata;
            TGT_SFR:  rsp_byte = s_q.rsp_sfr;
            default:  rsp_byte = 8'h00;
        endcase
        if (!s_q.rsp_valid)  rd_data = 8'h00;
        else if (s_q.rsp_bit) rd_data = {7'b0000000, rsp_byte[s_q.rsp_pos]};
        else                  rd_data = rsp_byte;
    end

    assign rd_valid = s_q.rsp_valid;
    assign ext_req  = s_q.ext_req;
    assign ext_addr = s_q.ext_addr;

endmodule

// File: rtl/idm_checker.sv
module idm_checker #(
    parameter int XADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         req_op,
    input logic               req_write,
    input logic [XADDR_W-1:0] req_addr,
    input logic [7:0]         req_wdata,
    input logic               rd_valid,
    input logic               ext_req,
    input logic [7:0]         sp_now,
    input logic               xen_now
);
    assert_sp_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_now == 8'h07 && !xen_now));

    assert_push_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> (sp_now == $past(sp_now) + 8'd1));

    assert_pop_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd6) |=> (sp_now == $past(sp_now) - 8'd1));

    assert_sp_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && req_write && req_addr[7:0] == 8'h81)
        |=> (sp_now == $past(req_wdata)));

    assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && req_write && req_addr[7:0] == 8'hBF)
        |=> (xen_now == $past(req_wdata[0])));

    assert_ext_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> $past(req_valid && req_op == 3'd3));

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && (req_op == 3'd6 || (!req_write && req_op != 3'd5))));
endmodule

bind idata_mem_unit idm_checker #(.XADDR_W(XADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .ext_req(ext_req), .sp_now(sp_now), .xen_now(xen_now)
);

// File: tb/idata_mem_unit_test.sv
`timescale 1ns/1ps
module idata_mem_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        rd_valid, ext_req;
    logic [7:0]  rd_data;
    logic [15:0] ext_addr;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    idata_mem_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ext_req(ext_req), .ext_addr(ext_addr)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        chk;
        logic [7:0]  exp;
        logic        ext;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{3'd0,1'b1,16'h0030,8'hA5,1'b0,8'h00,1'b0,4'd2},   // R2 direct write
        '{3'd1,1'b0,16'h0030,8'h00,1'b1,8'hA5,1'b0,4'd2},   // R2 indirect read
        '{3'd1,1'b1,16'h0090,8'h3C,1'b0,8'h00,1'b0,4'd3},   // R3
        '{3'd0,1'b0,16'h0090,8'h00,1'b1,8'h00,1'b0,4'd3},   // R3 direct hits SFR
        '{3'd1,1'b0,16'h0090,8'h00,1'b1,8'h3C,1'b0,4'd3},   // R3
        '{3'd0,1'b0,16'h0081,8'h00,1'b1,8'h07,1'b0,4'd8},   // R8
        '{3'd4,1'b1,16'h0002,8'h11,1'b0,8'h00,1'b0,4'd4},   // R4 bank 0
        '{3'd0,1'b0,16'h0002,8'h00,1'b1,8'h11,1'b0,4'd4},
        '{3'd0,1'b1,16'h00D0,8'h18,1'b0,8'h00,1'b0,4'd4},   // R4 bank 3
        '{3'd4,1'b1,16'h0002,8'h22,1'b0,8'h00,1'b0,4'd4},
        '{3'd0,1'b0,16'h001A,8'h00,1'b1,8'h22,1'b0,4'd4},
        '{3'd4,1'b0,16'h0002,8'h00,1'b1,8'h22,1'b0,4'd4},
        '{3'd0,1'b0,16'h0002,8'h00,1'b1,8'h11,1'b0,4'd4},
        '{3'd0,1'b1,16'h00D0,8'h00,1'b0,8'h00,1'b0,4'd4},
        '{3'd0,1'b1,16'h0021,8'h00,1'b0,8'h00,1'b0,4'd5},   // R5
        '{3'd2,1'b1,16'h000B,8'h01,1'b0,8'h00,1'b0,4'd5},
        '{3'd0,1'b0,16'h0021,8'h00,1'b1,8'h08,1'b0,4'd5},
        '{3'd0,1'b1,16'h0022,8'hFF,1'b0,8'h00,1'b0,4'd5},
        '{3'd2,1'b1,16'h0013,8'h00,1'b0,8'h00,1'b0,4'd5},
        '{3'd0,1'b0,16'h0022,8'h00,1'b1,8'hF7,1'b0,4'd5},
        '{3'd2,1'b0,16'h0013,8'h00,1'b1,8'h00,1'b0,4'd5},
        '{3'd2,1'b0,16'h0012,8'h00,1'b1,8'h01,1'b0,4'd5},
        '{3'd5,1'b0,16'h0000,8'h5A,1'b0,8'h00,1'b0,4'd6},   // R6 push
        '{3'd0,1'b0,16'h0081,8'h00,1'b1,8'h08,1'b0,4'd6},
        '{3'd0,1'b0,16'h0008,8'h00,1'b1,8'h5A,1'b0,4'd6},
        '{3'd6,1'b0,16'h0000,8'h00,1'b1,8'h5A,1'b0,4'd7},   // R7 pop
        '{3'd0,1'b0,16'h0081,8'h00,1'b1,8'h07,1'b0,4'd7},
        '{3'd3,1'b0,16'h0010,8'h00,1'b1,8'h00,1'b1,4'd10},  // R10 disabled
        '{3'd0,1'b1,16'h00BF,8'h01,1'b0,8'h00,1'b0,4'd9},   // R9 enable
        '{3'd3,1'b1,16'h0010,8'h77,1'b0,8'h00,1'b0,4'd9},
        '{3'd3,1'b0,16'h0010,8'h00,1'b1,8'h77,1'b0,4'd9},
        '{3'd3,1'b0,16'h0300,8'h00,1'b1,8'h00,1'b1,4'd10},  // R10 out of range
        '{3'd0,1'b1,16'h0082,8'h34,1'b0,8'h00,1'b0,4'd8},   // R8
        '{3'd0,1'b1,16'h0083,8'h12,1'b0,8'h00,1'b0,4'd8},
        '{3'd0,1'b0,16'h0082,8'h00,1'b1,8'h34,1'b0,4'd8},
        '{3'd0,1'b0,16'h0083,8'h00,1'b1,8'h12,1'b0,4'd8},
        '{3'd0,1'b1,16'h0085,8'h55,1'b0,8'h00,1'b0,4'd11},  // R11 unused SFR
        '{3'd0,1'b0,16'h0085,8'h00,1'b1,8'h00,1'b0,4'd11},
        '{3'd0,1'b0,16'h00BF,8'h00,1'b1,8'h01,1'b0,4'd9}
    };

    task automatic expect_val(input string tag, input string what,
                              input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic wr,
                         input logic [15:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_op = op; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] op, input logic [15:0] a,
                         input logic [7:0] exp, input string tag);
        issue(op, 1'b0, a, 8'h00);
        expect_val(tag, "rd_valid", {15'd0, rd_valid}, 16'd1);
        expect_val(tag, "rd_data", {8'd0, rd_data}, {8'd0, exp});
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R1", "ext_req at reset", {15'd0, ext_req}, 16'd0);
        expect_val("R11", "rd_valid at reset", {15'd0, rd_valid}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            logic exp_valid;
            v = VEC[i];
            tg = $sformatf("R%0d", v.tag);
            exp_valid = (v.op == 3'd6) || (!v.wr && v.op != 3'd5);
            issue(v.op, v.wr, v.addr, v.wd);
            expect_val(tg, "rd_valid", {15'd0, rd_valid}, {15'd0, exp_valid});
            expect_val(tg, "ext_req", {15'd0, ext_req}, {15'd0, v.ext});
            if (v.chk) expect_val(tg, "rd_data", {8'd0, rd_data}, {8'd0, v.exp});
        end

        // R9 upper boundary of the expanded RAM
        issue(3'd3, 1'b1, 16'h02FF, 8'hC3);
        expect_val("R9", "ext_req at 02FF", {15'd0, ext_req}, 16'd0);
        do_rd(3'd3, 16'h02FF, 8'hC3, "R9");
        // R10 strobe and address of a miss, one cycle only
        issue(3'd3, 1'b1, 16'h0400, 8'h09);
        expect_val("R10", "ext_req", {15'd0, ext_req}, 16'd1);
        expect_val("R10", "ext_addr", ext_addr, 16'h0400);
        @(negedge clk);
        expect_val("R10", "ext_req single pulse", {15'd0, ext_req}, 16'd0);
        // R10 a miss while disabled leaves the expanded RAM untouched
        issue(3'd0, 1'b1, 16'h00BF, 8'h00);
        issue(3'd3, 1'b1, 16'h0010, 8'hEE);
        expect_val("R10", "ext_req disabled", {15'd0, ext_req}, 16'd1);
        issue(3'd0, 1'b1, 16'h00BF, 8'h01);
        do_rd(3'd3, 16'h0010, 8'h77, "R10");

        // R6 / R7 wrap of the stack pointer
        issue(3'd0, 1'b1, 16'h0081, 8'hFF);
        issue(3'd5, 1'b0, 16'h0000, 8'h99);
        do_rd(3'd0, 16'h0081, 8'h00, "R6");
        do_rd(3'd0, 16'h0000, 8'h99, "R6");
        do_rd(3'd6, 16'h0000, 8'h99, "R7");
        do_rd(3'd0, 16'h0081, 8'hFF, "R7");
        // R6 push crossing into the upper RAM
        issue(3'd0, 1'b1, 16'h0081, 8'h7F);
        issue(3'd5, 1'b0, 16'h0000, 8'h4E);
        do_rd(3'd1, 16'h0080, 8'h4E, "R6");
        do_rd(3'd0, 16'h0080, 8'h00, "R3");
        // R5 bit address above 7Fh is ignored
        issue(3'd2, 1'b1, 16'h0085, 8'h01);
        do_rd(3'd2, 16'h0085, 8'h00, "R5");
        do_rd(3'd0, 16'h0085, 8'h00, "R5");
        do_rd(3'd0, 16'h0021, 8'h08, "R5");

        // R1 reset in mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_rd(3'd0, 16'h0081, 8'h07, "R1");
        do_rd(3'd0, 16'h00D0, 8'h00, "R1");
        do_rd(3'd0, 16'h00BF, 8'h00, "R1");
        do_rd(3'd0, 16'h0082, 8'h00, "R1");
        do_rd(3'd0, 16'h0083, 8'h00, "R1");
        issue(3'd4, 1'b1, 16'h0001, 8'h66);
        do_rd(3'd0, 16'h0001, 8'h66, "R1");
        issue(3'd3, 1'b0, 16'h0010, 8'h00);
        expect_val("R1", "ext_req after reset", {15'd0, ext_req}, 16'd1);
        expect_val("R1", "rd_data after reset miss", {8'd0, rd_data}, 16'd0);

        finish_run();
    end
endmodule